// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits next to a small processor core and converts the four kinds of trap event into an ordinary subroutine call to one software handler. The four kinds are divide by zero, illegal instruction, software interrupt and external interrupt request. At each instruction boundary the core reports the boundary's address, its byte length and any synchronous events it raised. The block also samples the level-sensitive interrupt request at that boundary. Every event is latched into its own pending slot, together with the return address it will push.

When an event is pending, the block picks one by fixed priority and asks the core's stack logic to push the return address over a valid/ready handshake. In the cycle the push is accepted it does three things. It steers the program counter to the handler address. It records the cause code. For interrupt causes, it also records the interrupt number. A handler finds the cause and the number by reading three special registers through a one-cycle get/set port. It returns with a normal return instruction.

Top module: `exc_dispatch`

## Requirements
- R1: After reset all three special registers read zero and `push_valid`, `pc_redirect` and `irq_ack` are low.
- R2: Index 1 of the get/set port is the handler address: a write is read back on the next cycle. Index 0 reads zero and a write to it changes nothing.
- R3: When an entry commits, special register 2 takes the cause code: 0 divide by zero, 1 illegal instruction, 2 external interrupt, 3 software interrupt.
- R4: For causes 2 and 3 special register 3 takes the 4-bit number that came with the event. For causes 0 and 1 it keeps its value.
- R5: `push_data` is the boundary address plus the boundary length in bytes, for example +2 for a divide and +6 for a software interrupt. On commit `pc_target` equals the handler address.
- R6: `pc_redirect` is high only in the cycle `push_valid` and `push_ready` are both high. While `push_ready` is low, `push_valid` stays high and `push_data` holds.
- R7: Events pending together are taken one entry each in the order illegal, divide, software interrupt, external interrupt. Each of them pushes the return address of its own boundary.
- R8: `irq_req` is sampled only in cycles with `bnd_valid` high. `irq_ack` is a single-cycle pulse in the commit cycle of an external-interrupt entry.
- R9: Events arriving while an entry is in progress are kept and taken afterwards. Special registers 2 and 3 do not change during an entry except at its commit, and port writes to them in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_idx | input | 2 | Special register index for get and set |
| sr_wr_en | input | 1 | Set strobe |
| sr_wr_data | input | 32 | Value to set |
| sr_rd_data | output | 32 | Value of the indexed register |
| bnd_valid | input | 1 | An instruction completed this cycle |
| bnd_pc | input | 32 | Address of that instruction |
| bnd_len | input | 4 | Its length in bytes |
| bnd_div0 | input | 1 | It divided by zero |
| bnd_ill | input | 1 | It was illegal |
| bnd_swi | input | 1 | It was a software interrupt |
| bnd_swi_num | input | 4 | Software interrupt number |
| irq_req | input | 1 | External interrupt request, level |
| irq_num | input | 4 | External interrupt number |
| irq_ack | output | 1 | Interrupt taken pulse |
| push_valid | output | 1 | Return address push request |
| push_ready | input | 1 | Stack accepts the push |
| push_data | output | 32 | Return address to push |
| pc_redirect | output | 1 | Load the program counter |
| pc_target | output | 32 | Handler address |

## Verification
The bench builds the block with its default widths: 32-bit addresses, 4-bit interrupt numbers and 4-bit instruction lengths. At these widths every cause code and several distinct interrupt numbers can be driven, and return addresses can be built for 2-, 4- and 6-byte instructions. The bench raises all four events at one boundary to walk the whole priority chain. It holds off `push_ready` to exercise a stalled handshake. It also injects a new event and register writes in the middle of an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      CAUSE_DIV0    = 2'd0,
      CAUSE_ILLEGAL = 2'd1,
      CAUSE_IRQ     = 2'd2,
      CAUSE_SWI     = 2'd3
   } cause_e;

   localparam int N_CAUSE = 4;

   localparam logic [1:0] SR_ZERO    = 2'd0;
   localparam logic [1:0] SR_HANDLER = 2'd1;
   localparam logic [1:0] SR_CAUSE   = 2'd2;
   localparam logic [1:0] SR_NUM     = 2'd3;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_PUSH = 1'b1
   } entry_st_e;
endpackage

// File: rtl/exc_pending.sv
module exc_pending
   import exc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NUM_W  = 4,
   parameter int LEN_W  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bnd_valid,
   input  logic [ADDR_W-1:0]                 bnd_pc,
   input  logic [LEN_W-1:0]                  bnd_len,
   input  logic                              bnd_div0,
   input  logic                              bnd_ill,
   input  logic                              bnd_swi,
   input  logic [NUM_W-1:0]                  bnd_swi_num,
   input  logic                              irq_req,
   input  logic [NUM_W-1:0]                  irq_num,
   input  logic [N_CAUSE-1:0]                clr_vec,
   output logic [N_CAUSE-1:0]                pend,
   output logic [N_CAUSE-1:0][ADDR_W-1:0]    pend_ret,
   output logic [N_CAUSE-1:0][NUM_W-1:0]     pend_num
);
   logic [ADDR_W-1:0]             ret_addr;
   logic [N_CAUSE-1:0]            src;
   logic [N_CAUSE-1:0][NUM_W-1:0] src_num;

   assign ret_addr = bnd_pc + ADDR_W'(bnd_len);

   always_comb begin
      src                = '0;
      src_num            = '0;
      src[CAUSE_DIV0]    = bnd_div0;
      src[CAUSE_ILLEGAL] = bnd_ill;
      src[CAUSE_IRQ]     = irq_req;
      src[CAUSE_SWI]     = bnd_swi;
      src_num[CAUSE_IRQ] = irq_num;
      src_num[CAUSE_SWI] = bnd_swi_num;
   end

   for (genvar k = 0; k < N_CAUSE; k++) begin : g_slot
      logic raise, load;
      assign raise = bnd_valid & src[k];
      // A slot still waiting keeps its first capture; a slot being
      // retired this cycle may be refilled at once.
      assign load  = raise & (~pend[k] | clr_vec[k]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[k]     <= 1'b0;
            pend_ret[k] <= '0;
            pend_num[k] <= '0;
         end else begin
            pend[k] <= (pend[k] & ~clr_vec[k]) | raise;
            if (load) begin
               pend_ret[k] <= ret_addr;
               pend_num[k] <= src_num[k];
            end
         end
      end

      AST_SLOT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         pend[k] && !clr_vec[k] |=> pend[k] && $stable(pend_ret[k])) // R9
         else $error("pending slot lost or altered");
   end

   AST_IRQ_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[CAUSE_IRQ] && !bnd_valid |=> !pend[CAUSE_IRQ]) // R8
      else $error("interrupt captured outside a boundary");
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic [N_CAUSE-1:0] req,
   output logic [N_CAUSE-1:0] grant,
   output logic [1:0]         grant_idx
);
   // Rank 0 is served first.
   localparam logic [1:0] RANK [N_CAUSE] = '{
      CAUSE_ILLEGAL, CAUSE_DIV0, CAUSE_SWI, CAUSE_IRQ
   };

   always_comb begin
      grant     = '0;
      grant_idx = RANK[0];
      for (int i = N_CAUSE - 1; i >= 0; i--) begin
         if (req[RANK[i]]) begin
            grant     = '0;
            grant[RANK[i]] = 1'b1;
            grant_idx = RANK[i];
         end
      end
   end
endmodule

// File: rtl/exc_sregs.sv
module exc_sregs
   import exc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int NUM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       sr_idx,
   input  logic             sr_wr_en,
   input  logic [XLEN-1:0]  sr_wr_data,
   output logic [XLEN-1:0]  sr_rd_data,
   input  logic             entry_busy,
   input  logic             commit,
   input  cause_e           commit_cause,
   input  logic [NUM_W-1:0] commit_num,
   output logic [XLEN-1:0]  handler_addr
);
   localparam int PAD_CAUSE = XLEN - 2;
   localparam int PAD_NUM   = XLEN - NUM_W;

   logic [XLEN-1:0] handler_q, cause_q, num_q;
   logic            sw_open, cause_has_num;

   assign sw_open       = sr_wr_en & ~entry_busy;
   assign cause_has_num = (commit_cause == CAUSE_IRQ) || (commit_cause == CAUSE_SWI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         handler_q <= '0;
         cause_q   <= '0;
         num_q     <= '0;
      end else begin
         if (sr_wr_en && sr_idx == SR_HANDLER) handler_q <= sr_wr_data;
         if (commit) begin
            cause_q <= {{PAD_CAUSE{1'b0}}, commit_cause};
            if (cause_has_num) num_q <= {{PAD_NUM{1'b0}}, commit_num};
         end else if (sw_open) begin
            if (sr_idx == SR_CAUSE) cause_q <= sr_wr_data;
            if (sr_idx == SR_NUM)   num_q   <= sr_wr_data;
         end
      end
   end

   always_comb begin
      unique case (sr_idx)
         SR_HANDLER: sr_rd_data = handler_q;
         SR_CAUSE:   sr_rd_data = cause_q;
         SR_NUM:     sr_rd_data = num_q;
         default:    sr_rd_data = '0;
      endcase
   end

   assign handler_addr = handler_q;

   AST_CAUSE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> cause_q[1:0] == $past(commit_cause)) // R3
      else $error("cause code not recorded");
   AST_NUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      commit && !cause_has_num |=> $stable(num_q)) // R4
      else $error("number changed by a numberless cause");
   AST_NO_MIDENTRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      entry_busy && !commit |=> $stable(cause_q) && $stable(num_q)) // R9
      else $error("cause or number changed mid-entry");
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
   import exc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NUM_W  = 4,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sr_idx,
   input  logic              sr_wr_en,
   input  logic [ADDR_W-1:0] sr_wr_data,
   output logic [ADDR_W-1:0] sr_rd_data,
   input  logic              bnd_valid,
   input  logic [ADDR_W-1:0] bnd_pc,
   input  logic [LEN_W-1:0]  bnd_len,
   input  logic              bnd_div0,
   input  logic              bnd_ill,
   input  logic              bnd_swi,
   input  logic [NUM_W-1:0]  bnd_swi_num,
   input  logic              irq_req,
   input  logic [NUM_W-1:0]  irq_num,
   output logic              irq_ack,
   output logic              push_valid,
   input  logic              push_ready,
   output logic [ADDR_W-1:0] push_data,
   output logic              pc_redirect,
   output logic [ADDR_W-1:0] pc_target
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (NUM_W < 1 || NUM_W >= ADDR_W) begin : g_bad_num
      $error("NUM_W must lie between 1 and ADDR_W-1");
   end
   if (LEN_W < 1 || LEN_W >= ADDR_W) begin : g_bad_len
      $error("LEN_W must lie between 1 and ADDR_W-1");
   end

   logic [N_CAUSE-1:0]             pend, grant, clr_vec;
   logic [N_CAUSE-1:0][ADDR_W-1:0] pend_ret;
   logic [N_CAUSE-1:0][NUM_W-1:0]  pend_num;
   logic [1:0]                     grant_idx, sel_q;
   entry_st_e                      state_q;
   logic                           accept;
   logic [ADDR_W-1:0]              handler_addr;

   exc_pending #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .LEN_W(LEN_W)) u_pending (
      .clk         (clk),
      .rst_n       (rst_n),
      .bnd_valid   (bnd_valid),
      .bnd_pc      (bnd_pc),
      .bnd_len     (bnd_len),
      .bnd_div0    (bnd_div0),
      .bnd_ill     (bnd_ill),
      .bnd_swi     (bnd_swi),
      .bnd_swi_num (bnd_swi_num),
      .irq_req     (irq_req),
      .irq_num     (irq_num),
      .clr_vec     (clr_vec),
      .pend        (pend),
      .pend_ret    (pend_ret),
      .pend_num    (pend_num)
   );

   exc_arbiter u_arbiter (
      .req       (pend),
      .grant     (grant),
      .grant_idx (grant_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (|pend) begin
               state_q <= ST_PUSH;
               sel_q   <= grant_idx;
            end
            ST_PUSH: if (push_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign push_valid  = (state_q == ST_PUSH);
   assign push_data   = pend_ret[sel_q];
   assign accept      = push_valid & push_ready;
   assign pc_redirect = accept;
   assign pc_target   = handler_addr;
   assign irq_ack     = accept & (sel_q == CAUSE_IRQ);
   assign clr_vec     = accept ? (N_CAUSE'(1) << sel_q) : '0;

   exc_sregs #(.XLEN(ADDR_W), .NUM_W(NUM_W)) u_sregs (
      .clk          (clk),
      .rst_n        (rst_n),
      .sr_idx       (sr_idx),
      .sr_wr_en     (sr_wr_en),
      .sr_wr_data   (sr_wr_data),
      .sr_rd_data   (sr_rd_data),
      .entry_busy   (push_valid),
      .commit       (accept),
      .commit_cause (cause_e'(sel_q)),
      .commit_num   (pend_num[sel_q]),
      .handler_addr (handler_addr)
   );

   AST_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !push_ready |=> push_valid && $stable(push_data)) // R6
      else $error("push request dropped or changed while stalled");
   AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      pc_redirect |=> !pc_redirect && !push_valid) // R6
      else $error("redirect not a single pulse");
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack) // R8
      else $error("interrupt acknowledge longer than one cycle");
   AST_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~pend) == '0)) // R7
      else $error("grant not one of the pending events");
endmodule

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  sr_idx;
   logic        sr_wr_en;
   logic [31:0] sr_wr_data, sr_rd_data;
   logic        bnd_valid;
   logic [31:0] bnd_pc;
   logic [3:0]  bnd_len;
   logic        bnd_div0, bnd_ill, bnd_swi;
   logic [3:0]  bnd_swi_num;
   logic        irq_req;
   logic [3:0]  irq_num;
   logic        irq_ack, push_valid, push_ready, pc_redirect;
   logic [31:0] push_data, pc_target;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   localparam logic [31:0] HANDLER = 32'h0000_4000;

   // Stimulus table: kind uses the cause code of R3.
   localparam int NV = 5;
   localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd3, 2'd1, 2'd2, 2'd0};
   localparam logic [31:0] V_PC   [NV] = '{32'h100, 32'h200, 32'h300, 32'h400, 32'h500};
   localparam logic [3:0]  V_LEN  [NV] = '{4'd2, 4'd6, 4'd2, 4'd4, 4'd2};
   localparam logic [3:0]  V_NUM  [NV] = '{4'd0, 4'd5, 4'd0, 4'd9, 4'd0};
   localparam logic [31:0] V_RET  [NV] = '{32'h102, 32'h206, 32'h302, 32'h404, 32'h502};
   localparam logic [31:0] V_SR3  [NV] = '{32'd0, 32'd5, 32'd5, 32'd9, 32'd9};

   exc_dispatch u_dut (
      .clk(clk), .rst_n(rst_n),
      .sr_idx(sr_idx), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
      .sr_rd_data(sr_rd_data),
      .bnd_valid(bnd_valid), .bnd_pc(bnd_pc), .bnd_len(bnd_len),
      .bnd_div0(bnd_div0), .bnd_ill(bnd_ill), .bnd_swi(bnd_swi),
      .bnd_swi_num(bnd_swi_num), .irq_req(irq_req), .irq_num(irq_num),
      .irq_ack(irq_ack), .push_valid(push_valid), .push_ready(push_ready),
      .push_data(push_data), .pc_redirect(pc_redirect), .pc_target(pc_target)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_bnd();
      bnd_valid = 0; bnd_div0 = 0; bnd_ill = 0; bnd_swi = 0;
      bnd_pc = '0; bnd_len = '0; bnd_swi_num = '0;
   endtask

   task automatic read_sr(input logic [1:0] idx, output logic [31:0] val);
      sr_idx = idx; #1; val = sr_rd_data;
   endtask

   task automatic write_sr(input logic [1:0] idx, input logic [31:0] val);
      @(negedge clk); sr_idx = idx; sr_wr_en = 1; sr_wr_data = val;
      @(negedge clk); sr_wr_en = 0;
   endtask

   // One boundary cycle carrying the given events.
   task automatic boundary(input logic [31:0] pc, input logic [3:0] len,
                           input bit dv, input bit il, input bit sw,
                           input bit iq, input logic [3:0] num);
      @(negedge clk);
      bnd_valid = 1; bnd_pc = pc; bnd_len = len;
      bnd_div0 = dv; bnd_ill = il; bnd_swi = sw; bnd_swi_num = num;
      irq_req = iq; irq_num = num;
      @(negedge clk);
      clear_bnd(); irq_req = 0;
   endtask

   task automatic take_entry(input logic [1:0] ec, input logic [31:0] eret,
                             input logic [31:0] esr3, input int stall,
                             input string tag);
      logic [31:0] v;
      int w = 0;
      do begin
         @(negedge clk); #1; w++;
      end while (!push_valid && w < 50);
      check(push_valid, {tag, " R6 push request"}, 32'(push_valid), 1);
      check(push_data == eret, {tag, " R5 return address"}, push_data, eret);
      for (int s = 0; s < stall; s++) begin
         check(!pc_redirect, {tag, " R6 no redirect while stalled"}, 32'(pc_redirect), 0);
         @(negedge clk); #1;
         check(push_valid && push_data == eret, {tag, " R6 push held"}, push_data, eret);
      end
      push_ready = 1; #1;
      check(pc_redirect, {tag, " R6 redirect on accept"}, 32'(pc_redirect), 1);
      check(pc_target == HANDLER, {tag, " R5 handler target"}, pc_target, HANDLER);
      check(irq_ack == (ec == 2'd2), {tag, " R8 ack on interrupt only"},
            32'(irq_ack), 32'(ec == 2'd2));
      @(negedge clk);
      push_ready = 0; #1;
      check(!irq_ack && !pc_redirect, {tag, " R8 ack single pulse"}, 32'(irq_ack), 0);
      read_sr(2'd2, v);
      check(v == 32'(ec), {tag, " R3 cause code"}, v, 32'(ec));
      read_sr(2'd3, v);
      check(v == esr3, {tag, " R4 number register"}, v, esr3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 0; sr_idx = 0; sr_wr_en = 0; sr_wr_data = 0;
      push_ready = 0; irq_req = 0; irq_num = 0;
      clear_bnd();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;

      // R1: reset state
      check(!push_valid && !pc_redirect && !irq_ack, "R1 outputs idle",
            {29'd0, push_valid, pc_redirect, irq_ack}, 0);
      for (int i = 1; i < 4; i++) begin
         read_sr(2'(i), v);
         check(v == 0, "R1 special register zero", v, 0);
      end

      // R2: index 0 ignored, index 1 read back
      write_sr(2'd0, 32'hDEAD_BEEF);
      read_sr(2'd0, v);
      check(v == 0, "R2 index 0 reads zero", v, 0);
      read_sr(2'd1, v);
      check(v == 0, "R2 index 0 write left handler", v, 0);
      write_sr(2'd1, HANDLER);
      read_sr(2'd1, v);
      check(v == HANDLER, "R2 handler read back", v, HANDLER);

      // Table walk: R3 R4 R5 R6 R8
      for (int n = 0; n < NV; n++) begin
         boundary(V_PC[n], V_LEN[n], V_KIND[n] == 2'd0, V_KIND[n] == 2'd1,
                  V_KIND[n] == 2'd3, V_KIND[n] == 2'd2, V_NUM[n]);
         take_entry(V_KIND[n], V_RET[n], V_SR3[n], 0, $sformatf("vec%0d", n));
      end

      // R8: request level without a boundary is not taken
      @(negedge clk);
      irq_req = 1; irq_num = 4'd7;
      repeat (6) begin
         @(negedge clk); #1;
         check(!push_valid, "R8 no entry without boundary", 32'(push_valid), 0);
      end
      irq_req = 0;
      repeat (3) begin
         @(negedge clk); #1;
         check(!push_valid, "R8 dropped request not latched", 32'(push_valid), 0);
      end

      // R7: all four at once, first entry stalled (R6)
      boundary(32'h600, 4'd2, 1, 1, 1, 1, 4'hC);
      take_entry(2'd1, 32'h602, 32'd9,  3, "R7 illegal first");
      take_entry(2'd0, 32'h602, 32'd9,  0, "R7 divide second");
      take_entry(2'd3, 32'h602, 32'hC,  0, "R7 swi third");
      take_entry(2'd2, 32'h602, 32'hC,  0, "R7 irq last");

      // R9: event and register writes arriving mid-entry
      boundary(32'h800, 4'd6, 0, 0, 1, 0, 4'd7);
      do @(negedge clk); while (!push_valid);
      bnd_valid = 1; bnd_div0 = 1; bnd_pc = 32'h700; bnd_len = 4'd2;
      sr_idx = 2'd2; sr_wr_en = 1; sr_wr_data = 32'hFF;
      @(negedge clk);
      clear_bnd();
      sr_idx = 2'd3; sr_wr_data = 32'hEE;
      @(negedge clk);
      sr_wr_en = 0;
      read_sr(2'd2, v);
      check(v == 32'd2, "R9 cause not written mid-entry", v, 32'd2);
      read_sr(2'd3, v);
      check(v == 32'hC, "R9 number not written mid-entry", v, 32'hC);
      take_entry(2'd3, 32'h806, 32'd7, 0, "R9 current entry");
      take_entry(2'd0, 32'h702, 32'd7, 0, "R9 held event");

      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule